// File: doc/BRIEF.md
# Programmable Filter-Chain Sequencer

This block is the controller of a decimating filter chain. It does no arithmetic. It steps through a small loaded program that sets how many filter passes run, in which order, and how input samples pace them. The program memory and a sample threshold register are written through a plain register port while `run` is low.

While `run` is high the sequencer executes one word per step. A wait word holds the step until enough input samples are pending. A filter word sends a one-cycle start pulse to an external compute engine, together with the opaque filter settings and the output routing. The step then holds until the engine reports done. Load, jump and conditional-jump words build loops. Input samples are counted on every cycle, including while a filter pass is in flight.

The controller has three states. `ST_IDLE` holds step 0 and moves to `ST_EXEC` when `run` goes high. `ST_EXEC` runs one word per cycle. It moves to `ST_BUSY` on a filter word and back to `ST_IDLE` when `run` goes low. `ST_BUSY` returns to `ST_EXEC` on `fir_done` and moves to the next step at the same time.

Top module: `filter_seq`

## Requirements
- R1: After reset, the outputs are all zero: `step`, `pend_count`, `ovf_err` and `fir_start`. While `run` is low and no filter pass is in flight, `step` is 0. One cycle after `run` rises, execution begins at step 0.
- R2: A write with `cfg_addr` 0..31 stores `cfg_wdata` as program word `cfg_addr`. A write with address 32 stores `cfg_wdata[9:0]` as the wait threshold. The opcode sits in bits [23:21]: 1 = wait, 2 = filter, 3 = loop load, 4 = jump, 5 = conditional jump. Reset clears every word to 0.
- R3: A wait word advances to the next step in one cycle if `pend_count` is greater than or equal to the threshold. Otherwise it holds the step.
- R4: A filter word produces a one-cycle `fir_start` pulse one cycle after it executes. With the pulse, `fir_final` = bit 20, `fir_dest` = bits [19:15] and `fir_params` = bits [9:0]. The step holds until `fir_done` is seen, then advances by one.
- R5: When a filter word issues, `pend_count` drops by its consume field, bits [14:10]. The count does not go below 0.
- R6: A loop-load word copies bits [9:0] into the loop counter and advances. A conditional jump goes to the target in bits [4:0] and decrements the counter if the counter is nonzero. If the counter is zero it advances instead.
- R7: A jump word goes to the target in bits [4:0] in one cycle.
- R8: A word with opcode 0, 6 or 7 advances the step by one in one cycle and has no other effect.
- R9: Every cycle with `in_valid` high adds one to `pend_count`, whatever the state. If the count would pass 1023, it stays at 1023 and `ovf_err` is set. `ovf_err` then stays set until reset.
- R10: Take a chain of wait, filter (consume equal to the threshold T, routed to step 2), final filter, and jump to 0. Given K pending samples, it issues 2*floor(K/T) passes, of which floor(K/T) are final, and leaves K mod T samples pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Write address: 0..31 program, 32 threshold |
| cfg_wdata | input | 24 | Write data |
| run | input | 1 | Execute the program while high |
| in_valid | input | 1 | One input sample arrives this cycle |
| fir_done | input | 1 | Compute engine finished the current pass |
| fir_start | output | 1 | One-cycle start pulse to the compute engine |
| fir_params | output | 10 | Filter settings field of the issued word |
| fir_dest | output | 5 | Destination step for the pass output |
| fir_final | output | 1 | Pass output goes to the final output path |
| step | output | 5 | Current program step |
| pend_count | output | 10 | Input samples pending |
| ovf_err | output | 1 | Sticky pending-count overflow flag |

## Verification
The properties check these on every cycle: the start pulse lasts one cycle and follows each issue, the step is frozen while a pass is in flight, the step is held at zero when idle, and the pending counter increments, saturates and keeps its error flag. Only the bench scenarios can show whole-program results. These are the pass counts over a sweep of thresholds and sample counts, the number of trips through a counted loop, the one-cycle cost of wait, jump and undefined words, stalling below the threshold, the floor at zero on consumption, and the field values that reach the engine.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int WORD_W  = 24;
    localparam int OP_LSB  = 21;
    localparam int FIN_BIT = 20;
    localparam int DST_LSB = 15;
    localparam int STEP_W  = 5;
    localparam int CNS_LSB = 10;
    localparam int CNS_W   = 5;
    localparam int PRM_W   = 10;

    localparam logic [2:0] OP_WAIT = 3'd1;
    localparam logic [2:0] OP_FILT = 3'd2;
    localparam logic [2:0] OP_LOAD = 3'd3;
    localparam logic [2:0] OP_JUMP = 3'd4;
    localparam logic [2:0] OP_CJMP = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_BUSY = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fseq_progmem.sv
module fseq_progmem #(
    parameter int STEP_W = 5,
    parameter int WORD_W = 24,
    parameter int THR_W  = 10,
    localparam int DEPTH = 1 << STEP_W,
    localparam int AW    = STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [STEP_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [THR_W-1:0]  thresh
);
    localparam logic [AW-1:0] THR_ADDR = AW'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic              prog_hit;

    assign prog_hit = we && !addr[AW-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (prog_hit) begin
            mem[addr[STEP_W-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          thresh <= '0;
        else if (we && addr == THR_ADDR)     thresh <= wdata[THR_W-1:0];
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/fseq_pending.sv
module fseq_pending #(
    parameter int CNT_W = 10,
    parameter int DEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec_en,
    input  logic [DEC_W-1:0] dec_amt,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    logic [CNT_W:0] sum;
    logic [CNT_W:0] dec_ext;
    logic [CNT_W:0] nxt;
    logic           ovf;

    assign dec_ext = {{(CNT_W + 1 - DEC_W){1'b0}}, dec_amt};

    always_comb begin
        sum = {1'b0, count} + {{CNT_W{1'b0}}, inc};
        nxt = sum;
        if (dec_en) nxt = (sum >= dec_ext) ? (sum - dec_ext) : '0;
    end

    assign ovf = nxt[CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            count <= ovf ? '1 : nxt[CNT_W-1:0];
            err   <= err | ovf;
        end
    end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int LOOP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  pend,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              fir_done,
    output logic [STEP_W-1:0] pc,
    output logic              busy,
    output logic              issue,
    output logic [CNS_W-1:0]  consume,
    output logic              fir_start,
    output logic [PRM_W-1:0]  fir_params,
    output logic [STEP_W-1:0] fir_dest,
    output logic              fir_final
);
    seq_state_e        state, nstate;
    logic [STEP_W-1:0] npc, pc_inc, target;
    logic [LOOP_W-1:0] loop_cnt, nloop;
    logic [2:0]        op;

    assign op      = word[OP_LSB +: 3];
    assign target  = word[STEP_W-1:0];
    assign consume = word[CNS_LSB +: CNS_W];
    assign pc_inc  = pc + STEP_W'(1);
    assign busy    = (state == ST_BUSY);

    always_comb begin
        nstate = state;
        npc    = pc;
        nloop  = loop_cnt;
        issue  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                npc = '0;
                if (run) nstate = ST_EXEC;
            end
            ST_EXEC: begin
                if (!run) begin
                    nstate = ST_IDLE;
                    npc    = '0;
                end else begin
                    case (op)
                        OP_WAIT: if (pend >= thresh) npc = pc_inc;
                        OP_FILT: begin
                            issue  = 1'b1;
                            nstate = ST_BUSY;
                        end
                        OP_LOAD: begin
                            nloop = word[LOOP_W-1:0];
                            npc   = pc_inc;
                        end
                        OP_JUMP: npc = target;
                        OP_CJMP: begin
                            if (loop_cnt != '0) begin
                                npc   = target;
                                nloop = loop_cnt - LOOP_W'(1);
                            end else begin
                                npc = pc_inc;
                            end
                        end
                        default: npc = pc_inc;
                    endcase
                end
            end
            ST_BUSY: begin
                if (fir_done) begin
                    nstate = ST_EXEC;
                    npc    = pc_inc;
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pc       <= '0;
            loop_cnt <= '0;
        end else begin
            state    <= nstate;
            pc       <= npc;
            loop_cnt <= nloop;
        end
    end

    // outputs to the compute engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fir_start  <= 1'b0;
            fir_params <= '0;
            fir_dest   <= '0;
            fir_final  <= 1'b0;
        end else begin
            fir_start <= issue;
            if (issue) begin
                fir_params <= word[PRM_W-1:0];
                fir_dest   <= word[DST_LSB +: STEP_W];
                fir_final  <= word[FIN_BIT];
            end
        end
    end

endmodule

// File: rtl/filter_seq.sv
module filter_seq
    import fseq_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int LOOP_W = 10,
    localparam int AW    = STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              run,
    input  logic              in_valid,
    input  logic              fir_done,
    output logic              fir_start,
    output logic [PRM_W-1:0]  fir_params,
    output logic [STEP_W-1:0] fir_dest,
    output logic              fir_final,
    output logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  pend_count,
    output logic              ovf_err
);
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  thresh;
    logic              busy;
    logic              issue;
    logic [CNS_W-1:0]  consume;

    fseq_progmem #(.STEP_W(STEP_W), .WORD_W(WORD_W), .THR_W(CNT_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rd_addr (step),
        .rd_word (word),
        .thresh  (thresh)
    );

    fseq_pending #(.CNT_W(CNT_W), .DEC_W(CNS_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (in_valid),
        .dec_en  (issue),
        .dec_amt (consume),
        .count   (pend_count),
        .err     (ovf_err)
    );

    fseq_ctrl #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .word       (word),
        .pend       (pend_count),
        .thresh     (thresh),
        .fir_done   (fir_done),
        .pc         (step),
        .busy       (busy),
        .issue      (issue),
        .consume    (consume),
        .fir_start  (fir_start),
        .fir_params (fir_params),
        .fir_dest   (fir_dest),
        .fir_final  (fir_final)
    );

endmodule

// File: rtl/filter_seq_chk.sv
module filter_seq_chk #(
    parameter int CNT_W  = 10,
    parameter int STEP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              in_valid,
    input logic              fir_done,
    input logic              fir_start,
    input logic [STEP_W-1:0] step,
    input logic [CNT_W-1:0]  pend_count,
    input logic              ovf_err,
    input logic              busy,
    input logic              issue
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r1_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !busy) |=> (step == '0));

    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fir_start |=> !fir_start);

    a_r4_issue_start: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> fir_start);

    a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fir_done) |=> $stable(step));

    a_r9_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !issue && pend_count != CMAX) |=> (pend_count == $past(pend_count) + CNT_W'(1)));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !issue && pend_count == CMAX) |=> (ovf_err && pend_count == CMAX));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

endmodule

bind filter_seq filter_seq_chk #(.CNT_W(CNT_W), .STEP_W(fseq_pkg::STEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .in_valid   (in_valid),
    .fir_done   (fir_done),
    .fir_start  (fir_start),
    .step       (step),
    .pend_count (pend_count),
    .ovf_err    (ovf_err),
    .busy       (busy),
    .issue      (issue)
);

// File: tb/filter_seq_test.sv
`timescale 1ns/1ps
module filter_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        run = 1'b0;
    logic        in_valid = 1'b0;
    logic        fir_done = 1'b0;
    logic        fir_start;
    logic [9:0]  fir_params;
    logic [4:0]  fir_dest;
    logic        fir_final;
    logic [4:0]  step;
    logic [9:0]  pend_count;
    logic        ovf_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int eng_cnt = 0;
    int starts = 0;
    int finals = 0;
    int last_dest = 0;
    int last_prm = 0;
    int last_fin = 0;

    always #2 clk = ~clk;

    filter_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .run(run), .in_valid(in_valid), .fir_done(fir_done),
        .fir_start(fir_start), .fir_params(fir_params), .fir_dest(fir_dest),
        .fir_final(fir_final), .step(step), .pend_count(pend_count), .ovf_err(ovf_err)
    );

    // compute engine model: done three cycles after a start
    always @(negedge clk) begin
        if (eng_cnt == 1) begin
            fir_done = 1'b1;
            eng_cnt  = 0;
        end else begin
            fir_done = 1'b0;
            if (eng_cnt > 1) eng_cnt = eng_cnt - 1;
        end
        if (fir_start) begin
            eng_cnt   = 3;
            starts    = starts + 1;
            if (fir_final) finals = finals + 1;
            last_dest = int'(fir_dest);
            last_prm  = int'(fir_params);
            last_fin  = int'(fir_final);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] w_op(input int op, input int low);
        return {3'(op), 21'(low)};
    endfunction

    function automatic logic [23:0] w_filt(input bit fin, input int dst, input int cns, input int prm);
        return {3'd2, fin, 5'(dst), 5'(cns), 10'(prm)};
    endfunction

    task automatic wr(input int a, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0, f0, kq, exp_k;
        do_reset();
        // R1: reset state
        chk(step == 0 && pend_count == 0 && !ovf_err && !fir_start, "R1 reset outputs",
            int'(step) + int'(pend_count) + int'(ovf_err), 0);

        // R8: undefined opcodes each take one cycle; R7 self jump holds
        wr(0, w_op(7, 0)); wr(1, w_op(6, 0)); wr(2, w_op(0, 0)); wr(3, w_op(4, 3));
        run = 1'b1;
        @(negedge clk); chk(step == 0, "R1 start at step 0", int'(step), 0);
        @(negedge clk); chk(step == 1, "R8 opcode 7 no-op", int'(step), 1);
        @(negedge clk); chk(step == 2, "R8 opcode 6 no-op", int'(step), 2);
        @(negedge clk); chk(step == 3, "R8 opcode 0 no-op", int'(step), 3);
        @(negedge clk); chk(step == 3, "R7 jump to self", int'(step), 3);
        chk(!fir_start && pend_count == 0, "R8 no side effect", int'(pend_count), 0);
        run = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(step == 0, "R1 run low returns to step 0", int'(step), 0);

        // R3/R7: wait with threshold 0 and jump alternate each cycle
        do_reset();
        wr(0, w_op(1, 0)); wr(1, w_op(4, 0)); wr(32, 24'd0);
        run = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(int'(step) == ((i % 2 == 0) ? 1 : 0), "R3 R7 one-cycle wait and jump",
                int'(step), (i % 2 == 0) ? 1 : 0);
        end
        run = 1'b0;

        // R3: stall below threshold, go on reaching it
        do_reset();
        wr(0, w_op(1, 0)); wr(1, w_op(4, 1)); wr(32, 24'd3);
        feed(2);
        run = 1'b1;
        repeat (6) @(negedge clk);
        chk(step == 0, "R3 stall below threshold", int'(step), 0);
        feed(1);
        repeat (3) @(negedge clk);
        chk(step == 1, "R3 advance at threshold", int'(step), 1);
        run = 1'b0;

        // R9: samples during a pass are counted; R4 step holds and fields
        do_reset();
        wr(0, w_filt(1'b1, 9, 0, 10'h2A5)); wr(1, w_op(4, 1));
        s0 = starts;
        run = 1'b1;
        feed(5);
        repeat (6) @(negedge clk);
        chk(pend_count == 5, "R9 count while busy", int'(pend_count), 5);
        chk(starts - s0 == 1, "R4 one start per filter word", starts - s0, 1);
        chk(last_dest == 9 && last_fin == 1, "R4 dest and final fields", last_dest, 9);
        chk(last_prm == 'h2A5, "R4 params field", last_prm, 'h2A5);
        chk(step == 1, "R4 advance after done", int'(step), 1);
        run = 1'b0;

        // R5: consumption floors at zero
        do_reset();
        wr(0, w_filt(1'b0, 4, 5, 1)); wr(1, w_op(4, 1));
        feed(2);
        run = 1'b1;
        repeat (8) @(negedge clk);
        chk(pend_count == 0, "R5 floor at zero", int'(pend_count), 0);
        chk(last_dest == 4 && last_fin == 0, "R4 routed to later step", last_dest, 4);
        run = 1'b0;

        // R9: overflow saturates and is sticky
        do_reset();
        feed(1023);
        chk(pend_count == 1023 && !ovf_err, "R9 full without error", int'(pend_count), 1023);
        feed(1);
        chk(pend_count == 1023 && ovf_err, "R9 overflow saturates and flags", int'(ovf_err), 1);
        feed(4);
        repeat (3) @(negedge clk);
        chk(ovf_err, "R9 error sticky", int'(ovf_err), 1);

        // R2 R10 R5: sweep thresholds and sample counts over a two-filter chain
        for (int t = 1; t <= 6; t++) begin
            for (int k = 0; k <= 13; k++) begin
                do_reset();
                wr(0, w_op(1, 0));
                wr(1, w_filt(1'b0, 2, t, t));
                wr(2, w_filt(1'b1, 0, 0, 0));
                wr(3, w_op(4, 0));
                wr(32, 24'(t));
                feed(k);
                s0 = starts; f0 = finals;
                run = 1'b1;
                repeat (250) @(negedge clk);
                kq = k / t;
                exp_k = k % t;
                chk(starts - s0 == 2 * kq, "R10 pass count", starts - s0, 2 * kq);
                chk(finals - f0 == kq, "R10 final pass count", finals - f0, kq);
                chk(int'(pend_count) == exp_k, "R5 R2 remaining samples", int'(pend_count), exp_k);
                run = 1'b0;
            end
        end

        // R6: counted loop runs n+1 passes
        for (int n = 0; n <= 6; n++) begin
            do_reset();
            wr(0, w_op(3, n));
            wr(1, w_filt(1'b1, 0, 0, 3));
            wr(2, w_op(5, 1));
            wr(3, w_op(4, 3));
            s0 = starts;
            run = 1'b1;
            repeat (120) @(negedge clk);
            chk(starts - s0 == n + 1, "R6 loop trip count", starts - s0, n + 1);
            chk(step == 3, "R6 falls through at zero", int'(step), 3);
            run = 1'b0;
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule